// File: doc/BRIEF.md
# CMI Line Encoder and Decoder

This block turns a serial NRZ bit stream into Coded Mark Inversion symbols for transmission, and turns received CMI symbols back into NRZ bits. It runs on one clock at the symbol rate, which is twice the bit rate. A bit enters on a bit enable and leaves as two half-bit symbols. On the receive side, symbols arrive on a symbol enable and are paired into bits. Each bit is reported with a code-violation flag.

Polarity can be inverted separately on the transmit output and on the receive input. Two loopback selects reroute the data. Remote loopback sends decoded receive bits back through the encoder. Local loopback sends the encoder's symbols into the decoder.

A half-bit alignment search counts code violations over fixed windows of decoded pairs. When a window holds too many violations, the decoder drops one symbol, which shifts its pairing by half a bit.

Top module: `cmi_codec`

## Requirements
- R1: Bit enables must be at least two cycles apart. Each accepted bit produces two symbols on `tx_sym`, with `tx_sym_vld` high in the two cycles after the enable. A 0 bit produces symbol 0 and then symbol 1.
- R2: A 1 bit produces two equal symbols. Successive 1 bits alternate between the pair 11 and the pair 00. The first 1 after reset produces 11, and 0 bits do not change the alternation.
- R3: When `cfg_tx_inv` is 1, every transmitted symbol is the complement of what it would be with `cfg_tx_inv` at 0.
- R4: The decoder pairs received symbols in arrival order. The pair 01 decodes to 0, and the pairs 00 and 11 decode to 1. The bit appears on `rx_bit` with `rx_bit_vld` high in the cycle after the second symbol of the pair is accepted.
- R5: When `cfg_rx_inv` is 1, each incoming `rx_sym` is complemented before it is paired.
- R6: `rx_cv` is raised with the decoded bit in two cases. The first is the pair 10, which is reported as bit 0. The second is an equal pair whose level matches the previous equal pair. After reset, the previous equal-pair level is taken as 0.
- R7: With `cfg_loc_lpbk`=1 and `cfg_rem_lpbk`=0, the decoder receives the encoder's uninverted symbols in place of `rx_sym`/`rx_sym_en`. The transmit output still runs.
- R8: With `cfg_rem_lpbk`=1 and `cfg_loc_lpbk`=0, decoded receive bits replace `tx_bit`/`tx_bit_en` at the encoder input.
- R9: With both loopback selects at 0, or both at 1, the block runs normally: the encoder takes `tx_bit` and the decoder takes `rx_sym`.
- R10: The decoder counts violations over windows of 64 decoded pairs. If a window holds more than 8 violations, `rx_slip` pulses for one cycle and the next received symbol is discarded. After that, pairing continues shifted by one symbol.
- R11: A window with no more than 8 violations causes no slip.
- R12: During reset and in the cycle after it, `tx_sym_vld`, `rx_bit_vld`, `rx_cv` and `rx_slip` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock, twice the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_tx_inv | input | 1 | Complement transmitted symbols |
| cfg_rx_inv | input | 1 | Complement received symbols before decoding |
| cfg_rem_lpbk | input | 1 | Remote loopback select |
| cfg_loc_lpbk | input | 1 | Local loopback select |
| tx_bit | input | 1 | NRZ bit to transmit |
| tx_bit_en | input | 1 | `tx_bit` is valid this cycle |
| rx_sym | input | 1 | Received CMI half-bit symbol |
| rx_sym_en | input | 1 | `rx_sym` is valid this cycle |
| tx_sym | output | 1 | Transmitted CMI half-bit symbol |
| tx_sym_vld | output | 1 | `tx_sym` is valid |
| rx_bit | output | 1 | Decoded NRZ bit |
| rx_bit_vld | output | 1 | `rx_bit` and `rx_cv` are valid |
| rx_cv | output | 1 | Code violation in the decoded pair |
| rx_slip | output | 1 | One-cycle pulse when the alignment shifts by a symbol |

## Verification
The bench drives streams that are offset by one symbol and made only of zeros. In that case every pair reads as 10, so a decoder whose window or threshold is wrong either never slips or slips again once it is aligned. A clean stream longer than one window must produce no slip.

Two same-level equal pairs in a row, and the first 1 after reset, catch an alternation state that starts at the wrong level or that 0 bits disturb. Junk driven on the bypassed inputs during each loopback catches a swapped select decode. Setting both selects together catches a design that lets either path win.

// File: rtl/cmi_pkg.sv
package cmi_pkg;

    typedef enum logic [1:0] {
        LM_NORMAL = 2'd0,
        LM_REMOTE = 2'd1,
        LM_LOCAL  = 2'd2
    } loop_mode_e;

    typedef struct packed {
        logic first;
        logic second;
    } cmi_pair_t;

    // Both selects together fall back to normal routing.
    function automatic loop_mode_e pick_mode(logic rem, logic loc);
        loop_mode_e m;
        case ({rem, loc})
            2'b10:   m = LM_REMOTE;
            2'b01:   m = LM_LOCAL;
            default: m = LM_NORMAL;
        endcase
        return m;
    endfunction

    function automatic cmi_pair_t encode_bit(logic b, logic lvl);
        cmi_pair_t p;
        if (b) begin
            p.first  = lvl;
            p.second = lvl;
        end else begin
            p.first  = 1'b0;
            p.second = 1'b1;
        end
        return p;
    endfunction

    function automatic logic pair_violates(cmi_pair_t p, logic last_lvl);
        return (p.first & ~p.second) | ((p.first == p.second) & (p.first == last_lvl));
    endfunction

endpackage

// File: rtl/cmi_enc.sv
module cmi_enc
    import cmi_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_bit,
    input  logic in_en,
    output logic sym_raw,
    output logic sym_vld
);
    logic      next_hi;
    logic      pend;
    logic      pend_vld;
    cmi_pair_t pair;

    always_comb pair = encode_bit(in_bit, next_hi);

    always_ff @(posedge clk) begin
        if (rst) begin
            next_hi  <= 1'b1;
            pend     <= 1'b0;
            pend_vld <= 1'b0;
            sym_raw  <= 1'b0;
            sym_vld  <= 1'b0;
        end else if (in_en) begin
            sym_raw  <= pair.first;
            pend     <= pair.second;
            pend_vld <= 1'b1;
            sym_vld  <= 1'b1;
            if (in_bit) next_hi <= ~next_hi;
        end else if (pend_vld) begin
            sym_raw  <= pend;
            pend_vld <= 1'b0;
            sym_vld  <= 1'b1;
        end else begin
            sym_vld  <= 1'b0;
        end
    end

    a_r1_two_symbols: assert property (@(posedge clk) disable iff (rst)
        in_en |=> sym_vld ##1 sym_vld);
    a_r1_zero_pair: assert property (@(posedge clk) disable iff (rst)
        (in_en && !in_bit) |=> (sym_raw == 1'b0) ##1 (sym_raw == 1'b1));
    a_r2_one_equal: assert property (@(posedge clk) disable iff (rst)
        (in_en && in_bit) |=> ##1 (sym_raw == $past(sym_raw)));
endmodule

// File: rtl/cmi_align.sv
module cmi_align #(
    parameter int WIN = 64,
    parameter int THR = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic pair_vld,
    input  logic pair_cv,
    output logic slip
);
    localparam int PAIR_W = $clog2(WIN);
    localparam int CNT_W  = $clog2(WIN + 1);

    logic [PAIR_W-1:0] pair_cnt;
    logic [CNT_W-1:0]  viol_cnt;
    logic [CNT_W-1:0]  total;

    always_comb total = viol_cnt + CNT_W'(pair_cv);

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_cnt <= '0;
            viol_cnt <= '0;
            slip     <= 1'b0;
        end else begin
            slip <= 1'b0;
            if (pair_vld) begin
                if (pair_cnt == PAIR_W'(WIN - 1)) begin
                    pair_cnt <= '0;
                    viol_cnt <= '0;
                    slip     <= (total > CNT_W'(THR));
                end else begin
                    pair_cnt <= pair_cnt + 1'b1;
                    viol_cnt <= total;
                end
            end
        end
    end

    // R10: a slip is a single-cycle pulse
    a_r10_slip_pulse: assert property (@(posedge clk) disable iff (rst)
        slip |=> !slip);
endmodule

// File: rtl/cmi_dec.sv
module cmi_dec
    import cmi_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sym,
    input  logic sym_en,
    input  logic slip,
    output logic bit_q,
    output logic vld_q,
    output logic cv_q
);
    logic      half;
    logic      skip;
    logic      first_q;
    logic      last_lvl;
    logic      drop;
    cmi_pair_t pair;

    always_comb begin
        drop        = sym_en & (slip | skip);
        pair.first  = first_q;
        pair.second = sym;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            half     <= 1'b0;
            skip     <= 1'b0;
            first_q  <= 1'b0;
            last_lvl <= 1'b0;
            bit_q    <= 1'b0;
            vld_q    <= 1'b0;
            cv_q     <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            cv_q  <= 1'b0;
            if (drop) begin
                skip <= 1'b0;
            end else begin
                if (slip) skip <= 1'b1;
                if (sym_en) begin
                    if (!half) begin
                        first_q <= sym;
                        half    <= 1'b1;
                    end else begin
                        half  <= 1'b0;
                        vld_q <= 1'b1;
                        bit_q <= (pair.first == pair.second);
                        cv_q  <= pair_violates(pair, last_lvl);
                        if (pair.first == pair.second) last_lvl <= sym;
                    end
                end
            end
        end
    end

    a_r4_pair_rate: assert property (@(posedge clk) disable iff (rst)
        vld_q |=> !vld_q);
    // R10: the symbol dropped on a slip yields no bit
    a_r10_drop_silent: assert property (@(posedge clk) disable iff (rst)
        (slip && sym_en) |=> !vld_q);
endmodule

// File: rtl/cmi_codec.sv
module cmi_codec
    import cmi_pkg::*;
#(
    parameter int WIN = 64,
    parameter int THR = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic cfg_tx_inv,
    input  logic cfg_rx_inv,
    input  logic cfg_rem_lpbk,
    input  logic cfg_loc_lpbk,
    input  logic tx_bit,
    input  logic tx_bit_en,
    input  logic rx_sym,
    input  logic rx_sym_en,
    output logic tx_sym,
    output logic tx_sym_vld,
    output logic rx_bit,
    output logic rx_bit_vld,
    output logic rx_cv,
    output logic rx_slip
);
    loop_mode_e mode;
    logic       enc_bit, enc_en, enc_raw, enc_vld;
    logic       dec_sym, dec_en;

    always_comb begin
        mode    = pick_mode(cfg_rem_lpbk, cfg_loc_lpbk);
        enc_bit = (mode == LM_REMOTE) ? rx_bit     : tx_bit;
        enc_en  = (mode == LM_REMOTE) ? rx_bit_vld : tx_bit_en;
        dec_sym = (mode == LM_LOCAL)  ? enc_raw    : (rx_sym ^ cfg_rx_inv);
        dec_en  = (mode == LM_LOCAL)  ? enc_vld    : rx_sym_en;
    end

    cmi_enc u_enc (
        .clk     (clk),
        .rst     (rst),
        .in_bit  (enc_bit),
        .in_en   (enc_en),
        .sym_raw (enc_raw),
        .sym_vld (enc_vld)
    );

    cmi_dec u_dec (
        .clk    (clk),
        .rst    (rst),
        .sym    (dec_sym),
        .sym_en (dec_en),
        .slip   (rx_slip),
        .bit_q  (rx_bit),
        .vld_q  (rx_bit_vld),
        .cv_q   (rx_cv)
    );

    cmi_align #(.WIN(WIN), .THR(THR)) u_align (
        .clk      (clk),
        .rst      (rst),
        .pair_vld (rx_bit_vld),
        .pair_cv  (rx_cv),
        .slip     (rx_slip)
    );

    always_comb begin
        tx_sym     = enc_raw ^ cfg_tx_inv;
        tx_sym_vld = enc_vld;
    end

    a_r8_remote_feeds_tx: assert property (@(posedge clk) disable iff (rst)
        (mode == LM_REMOTE && rx_bit_vld) |=> tx_sym_vld);
    a_r7_local_feeds_rx: assert property (@(posedge clk) disable iff (rst)
        (mode == LM_LOCAL && !enc_vld) |=> !rx_bit_vld);
endmodule

// File: tb/sim_cmi_codec.sv
module sim_cmi_codec;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_tx_inv = 1'b0, cfg_rx_inv = 1'b0, cfg_rem_lpbk = 1'b0, cfg_loc_lpbk = 1'b0;
    logic tx_bit = 1'b0, tx_bit_en = 1'b0, rx_sym = 1'b0, rx_sym_en = 1'b0;
    logic tx_sym, tx_sym_vld, rx_bit, rx_bit_vld, rx_cv, rx_slip;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmi_codec u0 (
        .clk(clk), .rst(rst),
        .cfg_tx_inv(cfg_tx_inv), .cfg_rx_inv(cfg_rx_inv),
        .cfg_rem_lpbk(cfg_rem_lpbk), .cfg_loc_lpbk(cfg_loc_lpbk),
        .tx_bit(tx_bit), .tx_bit_en(tx_bit_en),
        .rx_sym(rx_sym), .rx_sym_en(rx_sym_en),
        .tx_sym(tx_sym), .tx_sym_vld(tx_sym_vld),
        .rx_bit(rx_bit), .rx_bit_vld(rx_bit_vld),
        .rx_cv(rx_cv), .rx_slip(rx_slip)
    );

    int   n_chk = 0, n_fail = 0;
    logic txq[$];
    logic [1:0] rxq[$];
    logic tx_nh, rx_nh;
    logic txchk = 1'b1, rxchk = 1'b1, al_mode = 1'b0;
    int   slips = 0, post_bits = 0, post_bad = 0;
    logic done = 1'b0;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (rx_slip) slips++;
            if (tx_sym_vld && txchk) begin
                if (txq.size() == 0) chk(1'b0, "R9 unexpected tx symbol", 1, 0);
                else begin
                    logic e;
                    e = txq.pop_front();
                    chk(tx_sym == e, "R1/R2/R3/R8 tx symbol", int'(tx_sym), int'(e));
                end
            end
            if (rx_bit_vld && rxchk) begin
                if (rxq.size() == 0) chk(1'b0, "R9 unexpected rx bit", 1, 0);
                else begin
                    logic [1:0] e;
                    e = rxq.pop_front();
                    chk({rx_cv, rx_bit} == e, "R4/R5/R6/R7 rx {cv,bit}",
                        int'({rx_cv, rx_bit}), int'(e));
                end
            end
            if (rx_bit_vld && al_mode && slips > 0) begin
                post_bits++;
                if (post_bits > 4 && (rx_bit || rx_cv)) post_bad++;
            end
        end
    end

    task automatic push_tx_bit(input logic b);
        if (b) begin
            txq.push_back(tx_nh ^ cfg_tx_inv);
            txq.push_back(tx_nh ^ cfg_tx_inv);
            tx_nh = ~tx_nh;
        end else begin
            txq.push_back(1'b0 ^ cfg_tx_inv);
            txq.push_back(1'b1 ^ cfg_tx_inv);
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1; tx_bit_en = 1'b0; rx_sym_en = 1'b0;
        txq.delete(); rxq.delete();
        tx_nh = 1'b1; rx_nh = 1'b1; slips = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!tx_sym_vld && !rx_bit_vld && !rx_cv && !rx_slip, "R12 reset outputs",
            int'({tx_sym_vld, rx_bit_vld, rx_cv, rx_slip}), 0);
        @(posedge clk); #1; rst = 1'b0;
        @(negedge clk);
        chk(!tx_sym_vld && !rx_bit_vld && !rx_cv && !rx_slip, "R12 after reset",
            int'({tx_sym_vld, rx_bit_vld, rx_cv, rx_slip}), 0);
    endtask

    task automatic send_tx(input int n, input int pat, input logic to_rx);
        for (int i = 0; i < n; i++) begin
            logic b;
            b = (pat == 0) ? 1'b0 : (pat == 1) ? 1'b1 : 1'($urandom);
            push_tx_bit(b);
            if (to_rx) rxq.push_back({1'b0, b});
            @(posedge clk); #1; tx_bit = b; tx_bit_en = 1'b1;
            @(posedge clk); #1; tx_bit_en = 1'b0; tx_bit = ~b;
        end
    endtask

    task automatic send_sym(input logic s);
        @(posedge clk); #1; rx_sym = s ^ cfg_rx_inv; rx_sym_en = 1'b1;
    endtask

    task automatic send_rx(input int n, input int pat, input logic remote);
        for (int i = 0; i < n; i++) begin
            logic b;
            b = (pat == 0) ? 1'b0 : (pat == 1) ? 1'b1 : 1'($urandom);
            rxq.push_back({1'b0, b});
            if (remote) push_tx_bit(b);
            if (b) begin
                send_sym(rx_nh); send_sym(rx_nh); rx_nh = ~rx_nh;
            end else begin
                send_sym(1'b0); send_sym(1'b1);
            end
        end
        @(posedge clk); #1; rx_sym_en = 1'b0;
    endtask

    task automatic drain(input string tag);
        repeat (12) @(posedge clk);
        @(negedge clk);
        chk(txq.size() == 0, {tag, " tx queue drained"}, txq.size(), 0);
        chk(rxq.size() == 0, {tag, " rx queue drained"}, rxq.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 R2: zeros, ones, mixed; first 1 after reset is 11
        do_reset();
        send_tx(4, 1, 1'b0);
        send_tx(4, 0, 1'b0);
        send_tx(40, 2, 1'b0);
        drain("R1 R2");

        // R3: transmit inversion
        do_reset();
        cfg_tx_inv = 1'b1;
        send_tx(30, 2, 1'b0);
        drain("R3");
        cfg_tx_inv = 1'b0;

        // R4 R11: clean receive stream longer than one window
        do_reset();
        send_rx(150, 2, 1'b0);
        drain("R4");
        chk(slips == 0, "R11 no slip on clean stream", slips, 0);

        // R5: receive inversion
        do_reset();
        cfg_rx_inv = 1'b1;
        send_rx(40, 2, 1'b0);
        drain("R5");
        cfg_rx_inv = 1'b0;

        // R6: pair 10, then 11, 11 (repeat level), 00
        do_reset();
        rxq.push_back(2'b10);
        rxq.push_back(2'b01);
        rxq.push_back(2'b11);
        rxq.push_back(2'b01);
        send_sym(1'b1); send_sym(1'b0);
        send_sym(1'b1); send_sym(1'b1);
        send_sym(1'b1); send_sym(1'b1);
        send_sym(1'b0); send_sym(1'b0);
        @(posedge clk); #1; rx_sym_en = 1'b0;
        drain("R6");

        // R7: local loopback, junk on rx pins
        do_reset();
        cfg_loc_lpbk = 1'b1;
        rx_sym = 1'b1; rx_sym_en = 1'b1;
        send_tx(40, 2, 1'b1);
        rx_sym_en = 1'b0;
        drain("R7");
        cfg_loc_lpbk = 1'b0;

        // R8: remote loopback, tx pins held busy with junk
        do_reset();
        cfg_rem_lpbk = 1'b1;
        tx_bit = 1'b1; tx_bit_en = 1'b1;
        send_rx(40, 2, 1'b1);
        drain("R8");
        tx_bit_en = 1'b0;
        cfg_rem_lpbk = 1'b0;

        // R9: both selects set behaves as normal
        do_reset();
        cfg_rem_lpbk = 1'b1; cfg_loc_lpbk = 1'b1;
        send_rx(20, 2, 1'b0);
        send_tx(20, 2, 1'b0);
        drain("R9");
        cfg_rem_lpbk = 1'b0; cfg_loc_lpbk = 1'b0;

        // R10: stream offset by one symbol, all zeros
        do_reset();
        rxchk = 1'b0; al_mode = 1'b0; post_bits = 0; post_bad = 0;
        al_mode = 1'b1;
        send_sym(1'b0);
        send_rx(200, 0, 1'b0);
        repeat (8) @(posedge clk);
        @(negedge clk);
        chk(slips == 1, "R10 slip count", slips, 1);
        chk(post_bits > 100, "R10 bits after slip", post_bits, 101);
        chk(post_bad == 0, "R10 aligned after slip", post_bad, 0);
        al_mode = 1'b0; rxq.delete(); rxchk = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule